// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core and presents, at every moment, the register view of the current processor mode. Registers 0 to 7 and register 15 are common to every mode. The fast-interrupt mode owns private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each own private copies of registers 13 and 14 only, and see the user copies of registers 8 to 12. User and system modes share one bank.

The core reads through several combinational read ports and writes through one synchronous write port. A mode-change request loads a new 5-bit mode code, with bit 4 forced high, at the next clock edge. From that edge onward the read ports show the incoming mode's banked copies, and the outgoing mode's copies are kept intact. A side port reads or writes any register as it appears in a named mode. This lets exception and context-switch logic reach banked copies without changing mode. Every banked copy is a physical register selected by mode, so saving the outgoing bank and restoring the incoming one takes no extra cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode output reads 0x1F (system) and every register, in every mode, reads zero.
- R2: Read ports return the current mode's view of the indexed register combinationally. A write through the main port is visible on the read ports from the cycle after the clock edge.
- R3: A mode-change request loads the requested code with bit 4 forced to 1 at the next edge, so 0x00 to 0x03 become 0x10 to 0x13. Without a request the mode holds.
- R4: In fast-interrupt mode (0x11), registers 8 to 14 are private copies that no other mode's main-port access reads or writes.
- R5: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each have private registers 13 and 14, and share registers 8 to 12 with user mode.
- R6: User (0x10) and system (0x1F) modes see the same bank for registers 8 to 14.
- R7: Registers 0 to 7 and 15 are one set of registers common to every mode.
- R8: On leaving fast-interrupt mode, registers 8 to 12 read back the values last held by the user copies.
- R9: A main-port write in the same cycle as a mode change lands in the outgoing mode's view.
- R10: The side port reads or writes the register as seen in the named mode, with bit 4 of that mode forced to 1. Naming the current mode reaches the live register. Naming another mode reaches only that mode's copy.
- R11: An unrecognised mode code, for example 0x14 or 0x1A, is reported unchanged on the mode output and is banked as user mode.
- R12: When the main port and the side port write the same physical register in one cycle, the main-port value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 4*NUM_RD | Register index of each read port, port 0 in the low bits |
| rd_data_o | output | 32*NUM_RD | Read data of each read port, current-mode view |
| wr_en_i | input | 1 | Main write enable |
| wr_idx_i | input | 4 | Main write register index |
| wr_data_i | input | 32 | Main write data |
| mode_req_i | input | 1 | Mode-change request |
| mode_code_i | input | 5 | Requested mode code |
| mode_o | output | 5 | Current mode code |
| xm_we_i | input | 1 | Side-port write enable |
| xm_mode_i | input | 5 | Mode named by the side port |
| xm_idx_i | input | 4 | Side-port register index |
| xm_wdata_i | input | 32 | Side-port write data |
| xm_rdata_o | output | 32 | Side-port read data |

## Verification
A wrong slot decode makes a register alias between two modes. That alias shows on a read port or on the side port in the first cycle after the value is written, but only once the other mode is visited or named. The bench therefore alternates random mode changes with side-port accesses to other modes, so that every bank is touched often. A mode register that mishandles bit 4 or unknown codes shows on mode_o one cycle after the request. A write that loses a same-cycle race shows on the next read of that register.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int NREG   = 16;
  localparam int IDX_W  = 4;
  localparam int MODE_W = 5;
  localparam int NBANK  = 6;
  localparam int NMID   = 5;                          // registers 8..12
  localparam int NTOP   = 2;                          // registers 13..14
  localparam int MID_BASE  = 8;
  localparam int FIQ_BASE  = MID_BASE + NMID;
  localparam int TOP_BASE  = FIQ_BASE + NMID;
  localparam int PC_SLOT   = TOP_BASE + NTOP * NBANK;
  localparam int NSLOT     = PC_SLOT + 1;
  localparam int SLOT_W    = $clog2(NSLOT);

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  function automatic bank_e bank_of(logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;   // user, system and unknown codes
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(bank_e b, logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] off;
    if (i < 4'd8) begin
      return SLOT_W'(i);
    end else if (i == 4'd15) begin
      return SLOT_W'(PC_SLOT);
    end else if (i <= 4'd12) begin
      off = i - 4'd8;
      return (b == BK_FIQ) ? SLOT_W'(FIQ_BASE) + SLOT_W'(off)
                           : SLOT_W'(MID_BASE) + SLOT_W'(off);
    end else begin
      off = i - 4'd13;
      return SLOT_W'(TOP_BASE) + SLOT_W'({b, 1'b0}) + SLOT_W'(off);
    end
  endfunction
endpackage

// File: rtl/bank_mode_reg.sv
module bank_mode_reg
  import bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] code_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MD_SYS;
    else if (req_i) mode_q <= code_i | 5'h10;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bank_slot_map.sv
module bank_slot_map
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SLOT_W-1:0] slot_o
);
  bank_e bank;
  assign bank   = bank_of(mode_i | 5'h10);
  assign slot_o = slot_of(bank, idx_i);
endmodule

// File: rtl/bank_slot_store.sv
module bank_slot_store
  import bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NRP    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wa_en_i,
  input  logic [SLOT_W-1:0]     wa_slot_i,
  input  logic [DATA_W-1:0]     wa_data_i,
  input  logic                  wb_en_i,
  input  logic [SLOT_W-1:0]     wb_slot_i,
  input  logic [DATA_W-1:0]     wb_data_i,
  input  logic [NRP*SLOT_W-1:0] rd_slot_i,
  output logic [NRP*DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [NSLOT];

  // port a has priority over port b
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[s] <= '0;
      else if (wa_en_i && wa_slot_i == SLOT_W'(s))    mem[s] <= wa_data_i;
      else if (wb_en_i && wb_slot_i == SLOT_W'(s))    mem[s] <= wb_data_i;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    logic [SLOT_W-1:0] sl;
    assign sl = rd_slot_i[p*SLOT_W +: SLOT_W];
    assign rd_data_o[p*DATA_W +: DATA_W] = (sl < SLOT_W'(NSLOT)) ? mem[sl] : '0;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_RD*4-1:0]      rd_idx_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o,
  input  logic                     wr_en_i,
  input  logic [3:0]               wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     mode_req_i,
  input  logic [4:0]               mode_code_i,
  output logic [4:0]               mode_o,
  input  logic                     xm_we_i,
  input  logic [4:0]               xm_mode_i,
  input  logic [3:0]               xm_idx_i,
  input  logic [DATA_W-1:0]        xm_wdata_i,
  output logic [DATA_W-1:0]        xm_rdata_o
);
  localparam int NRP = NUM_RD + 1;   // read ports plus side port

  logic [MODE_W-1:0]     mode;
  logic [SLOT_W-1:0]     wr_slot, xm_slot;
  logic [NRP*SLOT_W-1:0] rd_slot;
  logic [NRP*DATA_W-1:0] rd_data;

  bank_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (mode_req_i),
    .code_i (mode_code_i),
    .mode_o (mode)
  );

  // write decodes against the outgoing mode
  bank_slot_map u_wmap (.mode_i(mode),      .idx_i(wr_idx_i), .slot_o(wr_slot));
  bank_slot_map u_xmap (.mode_i(xm_mode_i), .idx_i(xm_idx_i), .slot_o(xm_slot));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
    bank_slot_map u_rmap (
      .mode_i (mode),
      .idx_i  (rd_idx_i[p*IDX_W +: IDX_W]),
      .slot_o (rd_slot[p*SLOT_W +: SLOT_W])
    );
  end
  assign rd_slot[NUM_RD*SLOT_W +: SLOT_W] = xm_slot;

  bank_slot_store #(.DATA_W(DATA_W), .NRP(NRP)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wa_en_i   (wr_en_i),
    .wa_slot_i (wr_slot),
    .wa_data_i (wr_data_i),
    .wb_en_i   (xm_we_i),
    .wb_slot_i (xm_slot),
    .wb_data_i (xm_wdata_i),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_data)
  );

  assign rd_data_o  = rd_data[NUM_RD*DATA_W-1:0];
  assign xm_rdata_o = rd_data[NUM_RD*DATA_W +: DATA_W];
  assign mode_o     = mode;
endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_RD*4-1:0]      rd_idx_i,
  input logic [NUM_RD*DATA_W-1:0] rd_data_o,
  input logic                     wr_en_i,
  input logic [3:0]               wr_idx_i,
  input logic [DATA_W-1:0]        wr_data_i,
  input logic                     mode_req_i,
  input logic [4:0]               mode_code_i,
  input logic [4:0]               mode_o,
  input logic                     xm_we_i,
  input logic [4:0]               xm_mode_i,
  input logic [3:0]               xm_idx_i,
  input logic [DATA_W-1:0]        xm_wdata_i,
  input logic [DATA_W-1:0]        xm_rdata_o
);
  // R3
  mode_bit4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mode_o[4]);

  // R3
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_i |=> mode_o == ($past(mode_code_i) | 5'h10));

  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_req_i |=> $stable(mode_o));

  // R2
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_req_i) |=>
      (rd_idx_i[3:0] != $past(wr_idx_i)) || (rd_data_o[DATA_W-1:0] == $past(wr_data_i)));

  // R7
  common_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i < 4'd8 || wr_idx_i == 4'd15)) |=>
      (rd_idx_i[3:0] != $past(wr_idx_i)) || (rd_data_o[DATA_W-1:0] == $past(wr_data_i)));

  // R10
  xm_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((xm_mode_i | 5'h10) == mode_o) && (xm_idx_i == rd_idx_i[3:0])) |->
      xm_rdata_o == rd_data_o[DATA_W-1:0]);
endmodule

bind banked_regfile bank_rf_chk #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  localparam int DW = 32;
  localparam int NR = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR*4-1:0]  rd_idx_i = '0;
  logic [NR*DW-1:0] rd_data_o;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          mode_req_i = 1'b0;
  logic [4:0]    mode_code_i = '0;
  logic [4:0]    mode_o;
  logic          xm_we_i = 1'b0;
  logic [4:0]    xm_mode_i = 5'h10;
  logic [3:0]    xm_idx_i = '0;
  logic [DW-1:0] xm_wdata_i = '0;
  logic [DW-1:0] xm_rdata_o;

  always #2 clk_i = ~clk_i;   // 250 MHz

  banked_regfile #(.DATA_W(DW), .NUM_RD(NR)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  // reference state, organised by requirement R4..R7
  logic [DW-1:0] m_com [16];     // 0..7 and 15
  logic [DW-1:0] m_mid [2][5];   // [0] user-shared, [1] fast-interrupt
  logic [DW-1:0] m_top [6][2];   // r13/r14 per bank
  logic [4:0]    m_mode;

  function automatic int bank_f(logic [4:0] m);
    case (m | 5'h10)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] get_f(logic [4:0] m, logic [3:0] i);
    int b = bank_f(m);
    if (i < 8 || i == 15) return m_com[i];
    if (i <= 12) return m_mid[(b == 1) ? 1 : 0][i - 8];
    return m_top[b][i - 13];
  endfunction

  task automatic put_m(logic [4:0] m, logic [3:0] i, logic [DW-1:0] d);
    int b = bank_f(m);
    if (i < 8 || i == 15) m_com[i] = d;
    else if (i <= 12) m_mid[(b == 1) ? 1 : 0][i - 8] = d;
    else m_top[b][i - 13] = d;
  endtask

  task automatic cmp(logic [DW-1:0] act, logic [DW-1:0] exp, string tag, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic we, logic [3:0] wi, logic [DW-1:0] wd,
                      logic mv, logic [4:0] mc,
                      logic xw, logic [4:0] xm, logic [3:0] xi, logic [DW-1:0] xd,
                      logic [3:0] r0, logic [3:0] r1, string tag);
    @(negedge clk_i);
    wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    mode_req_i = mv; mode_code_i = mc;
    xm_we_i = xw; xm_mode_i = xm; xm_idx_i = xi; xm_wdata_i = xd;
    rd_idx_i = {r1, r0};
    #1;
    cmp(DW'(mode_o), DW'(m_mode), tag, "mode_o");
    cmp(rd_data_o[DW-1:0], get_f(m_mode, r0), tag, "rd0");
    cmp(rd_data_o[2*DW-1:DW], get_f(m_mode, r1), tag, "rd1");
    cmp(xm_rdata_o, get_f(xm, xi), tag, "xm_rdata");
    @(posedge clk_i);
    if (xw) put_m(xm, xi, xd);
    if (we) put_m(m_mode, wi, wd);   // main wins (R12), old mode (R9)
    if (mv) m_mode = mc | 5'h10;
  endtask

  task automatic look(logic [3:0] a, logic [3:0] b, string t);
    step(0, 0, 0, 0, 0, 0, 5'h10, a, 0, a, b, t);
  endtask
  task automatic wreg(logic [3:0] i, logic [DW-1:0] d, string t);
    step(1, i, d, 0, 0, 0, 5'h10, 0, 0, i, 0, t);
  endtask
  task automatic go(logic [4:0] m, string t);
    step(0, 0, 0, 1, m, 0, 5'h10, 13, 0, 13, 8, t);
  endtask
  task automatic xacc(logic w, logic [4:0] m, logic [3:0] i, logic [DW-1:0] d, string t);
    step(0, 0, 0, 0, 0, w, m, i, d, i, 13, t);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [4:0] codes [12] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B,
                             5'h1F, 5'h00, 5'h01, 5'h02, 5'h03, 5'h14};

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m_com[i] = '0;
    for (int i = 0; i < 5; i++) begin m_mid[0][i] = '0; m_mid[1][i] = '0; end
    for (int b = 0; b < 6; b++) begin m_top[b][0] = '0; m_top[b][1] = '0; end
    m_mode = 5'h1F;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset view
    for (int i = 0; i < 8; i++) look(4'(i), 4'(i + 8), "R1");
    xacc(0, 5'h11, 9, 0, "R1");
    xacc(0, 5'h1B, 14, 0, "R1");
    // R2 write then read
    wreg(2, 32'hA5A5_0002, "R2");
    look(2, 2, "R2");
    // R6 user/system share
    wreg(13, 32'h0000_D013, "R6");
    wreg(9, 32'h0000_0009, "R6");
    go(5'h10, "R6");
    look(13, 9, "R6");
    wreg(14, 32'h0000_E014, "R6");
    go(5'h1F, "R6");
    look(14, 13, "R6");
    // R4 fast-interrupt privacy, R8 restore on exit
    go(5'h11, "R4");
    look(9, 13, "R4");
    for (int i = 8; i < 15; i++) wreg(4'(i), 32'hF1F0_0000 + i, "R4");
    look(8, 14, "R4");
    go(5'h1F, "R8");
    look(9, 8, "R8");
    look(12, 13, "R8");
    // R5 two-register banks
    go(5'h12, "R5");
    wreg(13, 32'h1200_0013, "R5");
    wreg(10, 32'h1200_0010, "R5");
    go(5'h13, "R5");
    look(13, 10, "R5");
    wreg(14, 32'h1300_0014, "R5");
    go(5'h17, "R5");
    look(14, 13, "R5");
    go(5'h1B, "R5");
    look(14, 10, "R5");
    // R7 common registers
    wreg(3, 32'h0000_3333, "R7");
    wreg(15, 32'h0000_FFFF, "R7");
    go(5'h11, "R7");
    look(3, 15, "R7");
    // R3 legacy codes
    go(5'h01, "R3");
    go(5'h03, "R3");
    go(5'h00, "R3");
    look(13, 14, "R3");
    // R9 write coinciding with mode change
    step(1, 13, 32'h9999_0013, 1, 5'h12, 0, 5'h10, 13, 0, 13, 14, "R9");
    look(13, 14, "R9");
    xacc(0, 5'h10, 13, 0, "R9");
    // R10 side port
    xacc(1, 5'h11, 10, 32'hC0DE_0010, "R10");
    look(10, 11, "R10");
    xacc(0, 5'h11, 10, 0, "R10");
    xacc(1, 5'h12, 14, 32'hC0DE_0014, "R10");
    look(14, 13, "R10");
    xacc(1, 5'h02, 13, 32'hC0DE_0013, "R10");
    look(13, 14, "R10");
    go(5'h11, "R10");
    look(10, 9, "R10");
    // R11 unknown codes
    go(5'h14, "R11");
    look(13, 9, "R11");
    xacc(1, 5'h0A, 14, 32'h1A1A_0014, "R11");
    go(5'h1A, "R11");
    look(14, 13, "R11");
    go(5'h10, "R11");
    look(14, 13, "R11");
    // R12 same-slot race
    step(1, 13, 32'hAAAA_0013, 0, 0, 1, 5'h1F, 13, 32'hBBBB_0013, 13, 14, "R12");
    look(13, 14, "R12");
    step(1, 4, 32'hAAAA_0004, 0, 0, 1, 5'h12, 4, 32'hBBBB_0004, 4, 4, "R12");
    look(4, 4, "R12");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic we, mv, xw;
      we = ($urandom % 2) == 0;
      mv = ($urandom % 6) == 0;
      xw = ($urandom % 4) == 0;
      step(we, 4'($urandom), $urandom, mv, codes[$urandom % 12],
           xw, codes[$urandom % 12], 4'($urandom), $urandom,
           4'($urandom), 4'($urandom), "R2/R10");
    end
    look(0, 15, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule